// File: doc/BRIEF.md
# Camera Pixel Output Formatter

This block sits at the end of an image pipeline. It takes the colour components of the current pixel and drives an 8-bit parallel byte bus with a line-valid strobe (`out_hsync`), a frame strobe (`out_vsync`) and a pixel clock. The pixel clock is made from the system clock by a programmable divide ratio Np. Three byte formats are supported: raw Bayer with one byte per pixel, RGB565 with two bytes per pixel, and YCbCr 4:2:2 with interleaved luma and chroma bytes. Internal horizontal and vertical counters produce the line and frame timing. Blanking lengths are parameters.

The format and divider inputs may change at any time. The block takes them into use only where a new frame begins. A divide ratio that is too small for the chosen format is raised to the legal minimum, and this also sets a sticky error flag. The colour inputs are read at the system clock edge that opens each byte slot, so upstream logic only has to present the pixel that belongs to the current raster position.

Top module: `cam_pixel_formatter`

## Requirements
- R1: While reset is asserted and after it is released, until the first slot ends: `out_pclk`=1, `out_hsync`=0, `out_vsync`=1, `out_data`=0 and `cfg_err`=0. In this state the block runs as raw format with Np=1, parked on the last slot of a frame.
- R2: Every byte slot lasts exactly Np system clocks. In each slot `out_pclk` is low for the first floor(Np/2) clocks and high for the remaining clocks, so an odd Np gives an unequal duty cycle. With Np=1, `out_pclk` stays high. Data and sync outputs change only when a new slot begins, and a new slot never begins while `out_pclk` is high.
- R3: The format code on `cfg_fmt` is 0 for raw, 1 for RGB565, 2 for YCbCr 4:2:2 and 3 for reserved. The minimum Np is 1 for raw and 2 for the two-byte formats. A smaller Np is replaced by that minimum, and code 3 is run as raw. Both cases set `cfg_err`, which stays at 1 until reset.
- R4: `cfg_fmt` and `cfg_np` are sampled only at the edge that starts row 0 of a frame. Changes at any other time have no effect on the frame in progress.
- R5: In raw format a frame has RAW_H active rows of RAW_W bytes, one byte per pixel. Rows and columns are counted from 0. In an even row, even columns carry `px_g` and odd columns carry `px_r`. In an odd row, even columns carry `px_b` and odd columns carry `px_g`.
- R6: In RGB565 format a frame has PAIR_H rows of PAIR_W pixels, that is 2·PAIR_W bytes per line. The byte at an even byte position in the line is {`px_r`[7:3], `px_g`[7:5]}. The byte at the following odd position is {`px_g`[4:2], `px_b`[7:3]}.
- R7: In YCbCr 4:2:2 format the frame size is the same as in R6. Byte position p of a line carries `px_y` when p mod 4 is 0 or 2, `px_cb` when p mod 4 is 1, and `px_cr` when p mod 4 is 3.
- R8: `out_hsync` is high for exactly the active bytes of each active row, and low for HBLANK slots (at least one) after each line. While `out_hsync` is low, `out_data` is 0.
- R9: `out_vsync` is high for the VBLANK blank lines after the last active row and low during active rows. `out_hsync` stays low while `out_vsync` is high. Row 0 of the next frame starts in the slot where `out_vsync` falls.
- R10: The byte shown during a slot is formed from the `px_*` values present at the system clock edge that opened that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fmt | input | 2 | Requested byte format (0 raw, 1 RGB565, 2 YCbCr 4:2:2, 3 reserved) |
| cfg_np | input | NP_W | Requested pixel clock divide ratio |
| px_r | input | 8 | Red component of the current pixel |
| px_g | input | 8 | Green component of the current pixel |
| px_b | input | 8 | Blue component of the current pixel |
| px_y | input | 8 | Luma of the current pixel |
| px_cb | input | 8 | Blue-difference chroma |
| px_cr | input | 8 | Red-difference chroma |
| out_pclk | output | 1 | Generated pixel clock |
| out_hsync | output | 1 | Line-valid strobe; the byte is valid while it is high |
| out_vsync | output | 1 | Frame strobe; high during vertical blanking |
| out_data | output | 8 | Output byte |
| cfg_err | output | 1 | Sticky flag for an illegal format or divider request |

## Verification
A directed set of frames covers each format at even and odd divide ratios, then the illegal requests: Np=1 with RGB565, Np=0 with YCbCr, and the reserved code. The goal is to separate a correct byte split or interleave from a swapped one, and a correct duty cycle from an off-by-one phase. The pixel inputs change at random on every clock, so a byte taken from the wrong edge shows up as a wrong value. Between frame boundaries the configuration inputs carry random values, which exposes any sampling outside the start of row 0. A second reset after the error has been raised shows that the sticky flag clears and that random legal frames still follow the reference model.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

  typedef enum logic [1:0] {
    FMT_RAW    = 2'd0,
    FMT_RGB565 = 2'd1,
    FMT_YCC422 = 2'd2,
    FMT_RSVD   = 2'd3
  } pix_fmt_e;

  // formats that spend two bytes on every pixel
  function automatic logic two_byte(input pix_fmt_e f);
    return (f == FMT_RGB565) || (f == FMT_YCC422);
  endfunction

  // reserved code falls back to raw
  function automatic pix_fmt_e legal_fmt(input logic [1:0] code);
    return (code == 2'd3) ? FMT_RAW : pix_fmt_e'(code);
  endfunction

  function automatic logic [3:0] min_np(input pix_fmt_e f);
    return two_byte(f) ? 4'd2 : 4'd1;
  endfunction

  // Bayer site: even row G R G R, odd row B G B G
  function automatic logic [7:0] bayer_pick(input logic [7:0] r,
                                            input logic [7:0] g,
                                            input logic [7:0] b,
                                            input logic row_odd,
                                            input logic col_odd);
    if (row_odd == col_odd) return g;
    return row_odd ? b : r;
  endfunction

  // green is split: upper three bits in byte 0, lower three in byte 1
  function automatic logic [7:0] rgb565_pick(input logic [4:0] r5,
                                             input logic [5:0] g6,
                                             input logic [4:0] b5,
                                             input logic second);
    return second ? {g6[2:0], b5} : {r5, g6[5:3]};
  endfunction

  function automatic logic [7:0] ycc_pick(input logic [7:0] y,
                                          input logic [7:0] cb,
                                          input logic [7:0] cr,
                                          input logic [1:0] pos);
    case (pos)
      2'd1:    return cb;
      2'd3:    return cr;
      default: return y;
    endcase
  endfunction

endpackage

// File: rtl/pcf_clkdiv.sv
module pcf_clkdiv #(
  parameter int NP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP_W-1:0] np_cur,
  input  logic [NP_W-1:0] np_nxt,
  output logic            slot_end,
  output logic            pclk
);

  logic [NP_W-1:0] phase;
  logic [NP_W-1:0] phase_n;

  assign slot_end = (phase == (np_cur - NP_W'(1)));
  assign phase_n  = slot_end ? '0 : (phase + NP_W'(1));

  // low for floor(Np/2) clocks at slot start, then high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      pclk  <= 1'b1;
    end else begin
      phase <= phase_n;
      pclk  <= (phase_n >= (np_nxt >> 1));
    end
  end

endmodule

// File: rtl/pcf_raster.sv
module pcf_raster #(
  parameter int HC_W  = 11,
  parameter int VC_W  = 9,
  parameter int RST_H = 0,
  parameter int RST_V = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [HC_W-1:0] h_tot,
  input  logic [VC_W-1:0] v_tot,
  output logic [HC_W-1:0] h_nxt,
  output logic [VC_W-1:0] v_nxt,
  output logic            frame_last
);

  logic [HC_W-1:0] h_cnt;
  logic [VC_W-1:0] v_cnt;
  logic            line_last;

  assign line_last  = (h_cnt == (h_tot - HC_W'(1)));
  assign frame_last = line_last && (v_cnt == (v_tot - VC_W'(1)));

  always_comb begin
    h_nxt = line_last ? '0 : (h_cnt + HC_W'(1));
    if (!line_last)      v_nxt = v_cnt;
    else if (frame_last) v_nxt = '0;
    else                 v_nxt = v_cnt + VC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= HC_W'(RST_H);
      v_cnt <= VC_W'(RST_V);
    end else if (adv) begin
      h_cnt <= h_nxt;
      v_cnt <= v_nxt;
    end
  end

endmodule

// File: rtl/pcf_bytemux.sv
module pcf_bytemux
  import pcf_pkg::*;
#(
  parameter int RAW_W  = 644,
  parameter int RAW_H  = 484,
  parameter int PAIR_W = 640,
  parameter int PAIR_H = 480,
  parameter int HC_W   = 11,
  parameter int VC_W   = 9
) (
  input  pix_fmt_e        fmt,
  input  logic [HC_W-1:0] h,
  input  logic [VC_W-1:0] v,
  input  logic [7:0]      px_r,
  input  logic [7:0]      px_g,
  input  logic [7:0]      px_b,
  input  logic [7:0]      px_y,
  input  logic [7:0]      px_cb,
  input  logic [7:0]      px_cr,
  output logic            hs,
  output logic            vs,
  output logic [7:0]      byte_o
);

  localparam int PAIR_B = 2 * PAIR_W;

  logic [HC_W-1:0] line_bytes;
  logic [VC_W-1:0] rows;
  logic            in_rows;

  assign line_bytes = two_byte(fmt) ? HC_W'(PAIR_B) : HC_W'(RAW_W);
  assign rows       = two_byte(fmt) ? VC_W'(PAIR_H) : VC_W'(RAW_H);
  assign in_rows    = (v < rows);
  assign vs         = !in_rows;
  assign hs         = in_rows && (h < line_bytes);

  always_comb begin
    byte_o = 8'd0;
    if (hs) begin
      case (fmt)
        FMT_RGB565: byte_o = rgb565_pick(px_r[7:3], px_g[7:2], px_b[7:3], h[0]);
        FMT_YCC422: byte_o = ycc_pick(px_y, px_cb, px_cr, h[1:0]);
        default:    byte_o = bayer_pick(px_r, px_g, px_b, v[0], h[0]);
      endcase
    end
  end

endmodule

// File: rtl/cam_pixel_formatter.sv
module cam_pixel_formatter
  import pcf_pkg::*;
#(
  parameter int NP_W   = 4,
  parameter int RAW_W  = 644,
  parameter int RAW_H  = 484,
  parameter int PAIR_W = 640,
  parameter int PAIR_H = 480,
  parameter int HBLANK = 16,
  parameter int VBLANK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_fmt,
  input  logic [NP_W-1:0] cfg_np,
  input  logic [7:0]      px_r,
  input  logic [7:0]      px_g,
  input  logic [7:0]      px_b,
  input  logic [7:0]      px_y,
  input  logic [7:0]      px_cb,
  input  logic [7:0]      px_cr,
  output logic            out_pclk,
  output logic            out_hsync,
  output logic            out_vsync,
  output logic [7:0]      out_data,
  output logic            cfg_err
);

  localparam int RAW_HT  = RAW_W + HBLANK;
  localparam int PAIR_HT = 2 * PAIR_W + HBLANK;
  localparam int RAW_VT  = RAW_H + VBLANK;
  localparam int PAIR_VT = PAIR_H + VBLANK;
  localparam int H_MAX   = (RAW_HT > PAIR_HT) ? RAW_HT : PAIR_HT;
  localparam int V_MAX   = (RAW_VT > PAIR_VT) ? RAW_VT : PAIR_VT;
  localparam int HC_W    = $clog2(H_MAX);
  localparam int VC_W    = $clog2(V_MAX);

  // active configuration, held for a whole frame
  pix_fmt_e        fmt_act;
  logic [NP_W-1:0] np_act;

  // legalised request and frame-start events (named for the checker)
  pix_fmt_e        fmt_cfg;
  logic [NP_W-1:0] np_cfg;
  logic [NP_W-1:0] np_floor;
  logic            cfg_bad;
  logic            take_cfg;
  logic            slot_end;
  logic            frame_last;
  pix_fmt_e        fmt_nxt;
  logic [NP_W-1:0] np_nxt;

  logic [HC_W-1:0] h_tot;
  logic [VC_W-1:0] v_tot;
  logic [HC_W-1:0] h_nxt;
  logic [VC_W-1:0] v_nxt;
  logic            hs_nxt;
  logic            vs_nxt;
  logic [7:0]      byte_nxt;

  assign fmt_cfg  = legal_fmt(cfg_fmt);
  assign np_floor = NP_W'(min_np(fmt_cfg));
  assign np_cfg   = (cfg_np < np_floor) ? np_floor : cfg_np;
  assign cfg_bad  = (cfg_fmt == 2'd3) || (cfg_np < np_floor);

  assign take_cfg = slot_end && frame_last;
  assign fmt_nxt  = take_cfg ? fmt_cfg : fmt_act;
  assign np_nxt   = take_cfg ? np_cfg  : np_act;

  assign h_tot = two_byte(fmt_act) ? HC_W'(PAIR_HT) : HC_W'(RAW_HT);
  assign v_tot = two_byte(fmt_act) ? VC_W'(PAIR_VT) : VC_W'(RAW_VT);

  pcf_clkdiv #(.NP_W(NP_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .np_cur   (np_act),
    .np_nxt   (np_nxt),
    .slot_end (slot_end),
    .pclk     (out_pclk)
  );

  pcf_raster #(
    .HC_W  (HC_W),
    .VC_W  (VC_W),
    .RST_H (RAW_HT - 1),
    .RST_V (RAW_VT - 1)
  ) u_ras (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (slot_end),
    .h_tot      (h_tot),
    .v_tot      (v_tot),
    .h_nxt      (h_nxt),
    .v_nxt      (v_nxt),
    .frame_last (frame_last)
  );

  pcf_bytemux #(
    .RAW_W  (RAW_W),
    .RAW_H  (RAW_H),
    .PAIR_W (PAIR_W),
    .PAIR_H (PAIR_H),
    .HC_W   (HC_W),
    .VC_W   (VC_W)
  ) u_mux (
    .fmt    (fmt_nxt),
    .h      (h_nxt),
    .v      (v_nxt),
    .px_r   (px_r),
    .px_g   (px_g),
    .px_b   (px_b),
    .px_y   (px_y),
    .px_cb  (px_cb),
    .px_cr  (px_cr),
    .hs     (hs_nxt),
    .vs     (vs_nxt),
    .byte_o (byte_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_act   <= FMT_RAW;
      np_act    <= NP_W'(1);
      cfg_err   <= 1'b0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b1;
      out_data  <= 8'd0;
    end else begin
      if (take_cfg) begin
        fmt_act <= fmt_cfg;
        np_act  <= np_cfg;
        if (cfg_bad) cfg_err <= 1'b1;
      end
      if (slot_end) begin
        out_hsync <= hs_nxt;
        out_vsync <= vs_nxt;
        out_data  <= byte_nxt;
      end
    end
  end

endmodule

// File: rtl/pcf_checker.sv
module pcf_checker #(
  parameter int NP_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take_cfg,
  input logic            slot_end,
  input logic [1:0]      fmt_act,
  input logic [NP_W-1:0] np_act,
  input logic            cfg_err,
  input logic            out_pclk,
  input logic            out_hsync,
  input logic            out_vsync,
  input logic [7:0]      out_data
);

  AST_CFG_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !take_cfg |=> ($stable(fmt_act) && $stable(np_act))); // R4
  AST_NP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) (fmt_act != 2'd0) |-> (np_act >= NP_W'(2))); // R3
  AST_NP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) np_act != '0); // R3
  AST_FMT_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n) fmt_act != 2'd3); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |=> cfg_err); // R3
  AST_SLOT_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n) slot_end |=> (out_pclk == (np_act == NP_W'(1)))); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !slot_end |=> ($stable(out_data) && $stable(out_hsync) && $stable(out_vsync))); // R2
  AST_QUIET_BLANK: assert property (@(posedge clk) disable iff (!rst_n) !out_hsync |-> (out_data == 8'd0)); // R8
  AST_NO_LINE_IN_VBLANK: assert property (@(posedge clk) disable iff (!rst_n) out_vsync |-> !out_hsync); // R9

endmodule

bind cam_pixel_formatter pcf_checker #(.NP_W(NP_W)) u_pcf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .take_cfg  (take_cfg),
  .slot_end  (slot_end),
  .fmt_act   (fmt_act),
  .np_act    (np_act),
  .cfg_err   (cfg_err),
  .out_pclk  (out_pclk),
  .out_hsync (out_hsync),
  .out_vsync (out_vsync),
  .out_data  (out_data)
);

// File: tb/sim_cam_pixel_formatter.sv
module sim_cam_pixel_formatter;

  localparam int NP_W   = 4;
  localparam int RAW_W  = 6;
  localparam int RAW_H  = 4;
  localparam int PAIR_W = 4;
  localparam int PAIR_H = 3;
  localparam int HBLANK = 3;
  localparam int VBLANK = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      cfg_fmt = 2'd0;
  logic [NP_W-1:0] cfg_np = 4'd1;
  logic [7:0]      px_r = 8'd0, px_g = 8'd0, px_b = 8'd0;
  logic [7:0]      px_y = 8'd0, px_cb = 8'd0, px_cr = 8'd0;
  logic            out_pclk, out_hsync, out_vsync, cfg_err;
  logic [7:0]      out_data;

  always #5 clk = ~clk;

  cam_pixel_formatter #(
    .NP_W(NP_W), .RAW_W(RAW_W), .RAW_H(RAW_H), .PAIR_W(PAIR_W),
    .PAIR_H(PAIR_H), .HBLANK(HBLANK), .VBLANK(VBLANK)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_np(cfg_np),
    .px_r(px_r), .px_g(px_g), .px_b(px_b), .px_y(px_y), .px_cb(px_cb), .px_cr(px_cr),
    .out_pclk(out_pclk), .out_hsync(out_hsync), .out_vsync(out_vsync),
    .out_data(out_data), .cfg_err(cfg_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_phase, m_np, m_fmt, m_h, m_v, m_err, fc;
  int tgt_fmt, tgt_np;
  bit rand_legal;
  logic [7:0] s_r, s_g, s_b, s_y, s_cb, s_cr;

  function automatic int line_bytes(int f);
    return (f == 1 || f == 2) ? 2 * PAIR_W : RAW_W;
  endfunction

  function automatic int frame_rows(int f);
    return (f == 1 || f == 2) ? PAIR_H : RAW_H;
  endfunction

  function automatic bit is_active();
    return (m_v < frame_rows(m_fmt)) && (m_h < line_bytes(m_fmt));
  endfunction

  function automatic int exp_byte();
    logic [7:0] t;
    if (!is_active()) return 0;
    if (m_fmt == 1) begin
      if (m_h % 2 == 0) t = {s_r[7:3], s_g[7:5]};
      else              t = {s_g[4:2], s_b[7:3]};
      return int'(t);
    end
    if (m_fmt == 2) begin
      case (m_h % 4)
        0, 2:    return int'(s_y);
        1:       return int'(s_cb);
        default: return int'(s_cr);
      endcase
    end
    if ((m_v % 2) == (m_h % 2)) return int'(s_g);
    if (m_v % 2 == 1) return int'(s_b);
    return int'(s_r);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (frame %0d h=%0d v=%0d)",
               req, what, act, exp_v, fc, m_h, m_v);
    end
  endtask

  task automatic pick_target();
    if (!rand_legal && fc < 10) begin
      case (fc)
        0: begin tgt_fmt = 0; tgt_np = 1; end
        1: begin tgt_fmt = 0; tgt_np = 3; end
        2: begin tgt_fmt = 1; tgt_np = 2; end
        3: begin tgt_fmt = 2; tgt_np = 4; end
        4: begin tgt_fmt = 1; tgt_np = 3; end
        5: begin tgt_fmt = 2; tgt_np = 5; end
        6: begin tgt_fmt = 0; tgt_np = 2; end
        7: begin tgt_fmt = 1; tgt_np = 1; end  // too small for two bytes
        8: begin tgt_fmt = 2; tgt_np = 0; end  // zero ratio
        default: begin tgt_fmt = 3; tgt_np = 2; end  // reserved code
      endcase
    end else if (!rand_legal) begin
      tgt_fmt = int'($urandom % 4);
      tgt_np  = int'($urandom % 7);
    end else begin
      tgt_fmt = int'($urandom % 3);
      tgt_np  = ((tgt_fmt == 0) ? 1 : 2) + int'($urandom % 4);
    end
  endtask

  task automatic model_reset();
    m_phase = 0; m_np = 1; m_fmt = 0; m_err = 0;
    m_h = RAW_W + HBLANK - 1;
    m_v = RAW_H + VBLANK - 1;
    s_r = 0; s_g = 0; s_b = 0; s_y = 0; s_cb = 0; s_cr = 0;
  endtask

  // one system clock edge of the reference model
  task automatic model_step();
    int f;
    int n;
    int lo;
    if (m_phase == m_np - 1) begin
      m_phase = 0;
      if (m_h == line_bytes(m_fmt) + HBLANK - 1 && m_v == frame_rows(m_fmt) + VBLANK - 1) begin
        f = int'(cfg_fmt);
        n = int'(cfg_np);
        if (f == 3) begin f = 0; m_err = 1; end
        lo = (f == 0) ? 1 : 2;
        if (n < lo) begin n = lo; m_err = 1; end
        m_fmt = f; m_np = n; m_h = 0; m_v = 0;
        fc++;
        pick_target();
      end else if (m_h == line_bytes(m_fmt) + HBLANK - 1) begin
        m_h = 0; m_v++;
      end else begin
        m_h++;
      end
      s_r = px_r; s_g = px_g; s_b = px_b; s_y = px_y; s_cb = px_cb; s_cr = px_cr;
    end else begin
      m_phase++;
    end
  endtask

  task automatic compare_all();
    string tag;
    if (!is_active())    tag = "R8";
    else if (m_fmt == 1) tag = "R10 R6";
    else if (m_fmt == 2) tag = "R10 R7";
    else                 tag = "R10 R5";
    chk("R2 R4", "pclk", int'(out_pclk), (m_phase >= m_np / 2) ? 1 : 0);
    chk("R8", "hsync", int'(out_hsync), is_active() ? 1 : 0);
    chk("R9", "vsync", int'(out_vsync), (m_v >= frame_rows(m_fmt)) ? 1 : 0);
    chk("R3", "cfg_err", int'(cfg_err), m_err);
    chk(tag, "data", int'(out_data), exp_byte());
  endtask

  task automatic drive();
    px_r = 8'($urandom); px_g = 8'($urandom); px_b = 8'($urandom);
    px_y = 8'($urandom); px_cb = 8'($urandom); px_cr = 8'($urandom);
    if (m_v == frame_rows(m_fmt) + VBLANK - 1) begin
      cfg_fmt = 2'(tgt_fmt);
      cfg_np  = NP_W'(tgt_np);
    end else begin
      // R4: mid-frame noise on the configuration must not be taken
      cfg_fmt = 2'($urandom);
      cfg_np  = NP_W'($urandom);
    end
  endtask

  task automatic chk_reset();
    chk("R1", "pclk", int'(out_pclk), 1);
    chk("R1", "hsync", int'(out_hsync), 0);
    chk("R1", "vsync", int'(out_vsync), 1);
    chk("R1", "data", int'(out_data), 0);
    chk("R1", "cfg_err", int'(cfg_err), 0);
  endtask

  task automatic run_until(input int nframes);
    while (fc < nframes && !done) begin
      @(negedge clk);
      model_step();
      compare_all();
      drive();
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    model_reset();
    fc = 0;
    rand_legal = 1'b0;
    pick_target();
    cfg_fmt = 2'(tgt_fmt);
    cfg_np  = NP_W'(tgt_np);
    repeat (2) @(negedge clk);
    chk_reset();
    rst_n = 1'b1;
    run_until(22);
    // second reset clears the sticky flag (R1, R3)
    rst_n = 1'b0;
    model_reset();
    fc = 0;
    rand_legal = 1'b1;
    pick_target();
    cfg_fmt = 2'(tgt_fmt);
    cfg_np  = NP_W'(tgt_np);
    @(negedge clk);
    chk_reset();
    rst_n = 1'b1;
    run_until(6);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule